// File: doc/BRIEF.md
# Programmable Reference Divider and Phase-Frequency Detector

This block sits at the front of a frequency synthesizer loop. A counter divides the reference clock by a programmable ratio and emits a one-cycle comparison pulse once per period. Each comparison pulse is set against a feedback pulse from the loop's main divider. A three-state phase-frequency detector turns the difference into separate pump-up and pump-down requests, one for each direction of the charge pump.

A polarity input exchanges the two requests. The same block can then close a loop around an oscillator whose frequency rises with tuning voltage or one whose frequency falls. A ratio below the legal minimum of 3 is forced to 3 and flagged. A new ratio is taken only at the end of the current period, so a period is never cut short or stretched.

The comparison frequency is the reference frequency divided by the ratio. For example, a 4 MHz reference with a ratio of 16 gives 250 kHz, and with a ratio of 64 gives 62.5 kHz.

Top module: `ref_div_pfd`

## Requirements
- R1: While reset is asserted and directly after it, `cmp_pulse_o`, `up_o`, `dn_o` and `ratio_err_o` are all 0.
- R2: Once a ratio R in 3..32767 is active, `cmp_pulse_o` is high for exactly one cycle in every R clock cycles.
- R3: A ratio below 3 (0, 1 or 2) produces a period of 3 cycles. `ratio_err_o` is 1 while such a clamped ratio is active and 0 while a legal ratio is active.
- R4: A new ratio is sampled only in the cycle that ends a period. A change made in mid-period leaves the current period at the old length, and the following period uses the new ratio.
- R5: With polarity 0, a comparison pulse that arrives in idle, with no feedback pulse in the same cycle, raises `up_o` in the next cycle. `up_o` stays high until a feedback pulse arrives.
- R6: With polarity 0, a feedback pulse that arrives in idle raises `dn_o` in the next cycle. Once the other event arrives, both outputs are 0 in the following cycle.
- R7: A comparison pulse and a feedback pulse in the same cycle, starting from idle, leave both outputs at 0.
- R8: With polarity 1, the requests are exchanged. A leading comparison pulse raises `dn_o`, and a leading feedback pulse raises `up_o`.
- R9: Toggling `invert_i` changes which output is high in the same cycle and does not change the detector state. Returning it restores the original output.
- R10: `up_o` and `dn_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 15 | Division ratio R, sampled at each period end |
| invert_i | input | 1 | 1 exchanges the up and down requests |
| fb_pulse_i | input | 1 | One-cycle feedback pulse from the main divider, synchronous to clk_i |
| cmp_pulse_o | output | 1 | One-cycle comparison pulse, once per R cycles |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| ratio_err_o | output | 1 | Active ratio was clamped from below 3 |

## Verification
Four behaviours are checked on every cycle:
- the two requests are never high together;
- a comparison pulse is followed by at least two quiet cycles;
- the error flag moves only on a comparison pulse and agrees with the ratio sampled there;
- a lone leading event produces exactly one request, and a closing event clears both.

Only the bench's scenarios can show the exact period lengths, the clamp to 3, the deferred ratio change and the output exchange under polarity toggling. These depend on counting cycles between pulses and on comparing outputs before and after a polarity change.

// File: rtl/ref_pfd_pkg.sv
package ref_pfd_pkg;
  typedef enum logic [1:0] {
    PFD_IDLE    = 2'b00,
    PFD_REF_LED = 2'b01,
    PFD_FB_LED  = 2'b10
  } pfd_state_e;
endpackage

// File: rtl/ratio_clamp.sv
module ratio_clamp #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               low_o
);
  localparam logic [RATIO_W-1:0] MinVal = RATIO_W'(MIN_RATIO);

  always_comb begin
    low_o   = ratio_i < MinVal;
    ratio_o = low_o ? MinVal : ratio_i;
  end
endmodule

// File: rtl/ref_counter.sv
module ref_counter #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] load_ratio_i,
  input  logic               load_err_i,
  output logic               pulse_o,
  output logic               err_o
);
  localparam logic [RATIO_W-1:0] MinVal = RATIO_W'(MIN_RATIO);

  logic [RATIO_W-1:0] cnt_q, ratio_q;
  logic               term;

  assign term = (cnt_q == ratio_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= MinVal;
      err_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= term;
      if (term) begin
        // ratio only moves at period end
        cnt_q   <= '0;
        ratio_q <= load_ratio_i;
        err_o   <= load_err_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import ref_pfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ev_i,
  input  logic fb_ev_i,
  output logic ref_led_o,
  output logic fb_led_o
);
  pfd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PFD_IDLE: begin
        if (ref_ev_i && !fb_ev_i)      state_d = PFD_REF_LED;
        else if (fb_ev_i && !ref_ev_i) state_d = PFD_FB_LED;
      end
      PFD_REF_LED: if (fb_ev_i)  state_d = PFD_IDLE;
      PFD_FB_LED:  if (ref_ev_i) state_d = PFD_IDLE;
      default:                   state_d = PFD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PFD_IDLE;
    else         state_q <= state_d;
  end

  assign ref_led_o = (state_q == PFD_REF_LED);
  assign fb_led_o  = (state_q == PFD_FB_LED);
endmodule

// File: rtl/polarity_swap.sv
module polarity_swap (
  input  logic invert_i,
  input  logic a_i,
  input  logic b_i,
  output logic up_o,
  output logic dn_o
);
  assign up_o = invert_i ? b_i : a_i;
  assign dn_o = invert_i ? a_i : b_i;
endmodule

// File: rtl/ref_div_pfd.sv
module ref_div_pfd #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               invert_i,
  input  logic               fb_pulse_i,
  output logic               cmp_pulse_o,
  output logic               up_o,
  output logic               dn_o,
  output logic               ratio_err_o
);
  logic [RATIO_W-1:0] safe_ratio;
  logic               ratio_low;
  logic               ref_led, fb_led;

  ratio_clamp #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_clamp (
    .ratio_i (ratio_i),
    .ratio_o (safe_ratio),
    .low_o   (ratio_low)
  );

  ref_counter #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_ratio_i (safe_ratio),
    .load_err_i   (ratio_low),
    .pulse_o      (cmp_pulse_o),
    .err_o        (ratio_err_o)
  );

  pfd_core u_pfd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_ev_i  (cmp_pulse_o),
    .fb_ev_i   (fb_pulse_i),
    .ref_led_o (ref_led),
    .fb_led_o  (fb_led)
  );

  polarity_swap u_swap (
    .invert_i (invert_i),
    .a_i      (ref_led),
    .b_i      (fb_led),
    .up_o     (up_o),
    .dn_o     (dn_o)
  );
endmodule

// File: rtl/ref_div_pfd_chk.sv
module ref_div_pfd_chk #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               invert_i,
  input logic               fb_pulse_i,
  input logic               cmp_pulse_o,
  input logic               up_o,
  input logic               dn_o,
  input logic               ratio_err_o
);
  localparam logic [RATIO_W-1:0] MinVal = RATIO_W'(MIN_RATIO);

  AST_NEVER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o)); // R10

  AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |=> !cmp_pulse_o ##1 !cmp_pulse_o); // R2

  AST_ERR_AT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_err_o) |-> cmp_pulse_o); // R4

  AST_ERR_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ratio_err_o) |-> ($past(ratio_i) < MinVal)); // R3

  AST_ERR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ratio_err_o) |-> ($past(ratio_i) >= MinVal)); // R3

  AST_REF_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_pulse_o && !fb_pulse_i && !up_o && !dn_o)
      |=> ($countones({up_o, dn_o}) == 1)); // R5

  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && !invert_i && fb_pulse_i && !cmp_pulse_o) |=> (!up_o && !dn_o)); // R6

  AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_pulse_o && fb_pulse_i && !up_o && !dn_o) |=> (!up_o && !dn_o)); // R7
endmodule

bind ref_div_pfd ref_div_pfd_chk #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_chk (.*);

// File: tb/ref_div_pfd_test.sv
`timescale 1ns/1ps
module ref_div_pfd_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] ratio_i = 15'd20;
  logic        invert_i = 1'b0;
  logic        fb_pulse_i = 1'b0;
  logic        cmp_pulse_o, up_o, dn_o, ratio_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk_i = ~clk_i;

  ref_div_pfd uut (
    .clk_i, .rst_ni, .ratio_i, .invert_i, .fb_pulse_i,
    .cmp_pulse_o, .up_o, .dn_o, .ratio_err_o
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!cmp_pulse_o && n < 70000);
  endtask

  task automatic pulse_fb();
    fb_pulse_i = 1'b1;
    @(negedge clk_i);
    fb_pulse_i = 1'b0;
  endtask

  task automatic to_idle();
    int n;
    wait_pulse(n);
    @(negedge clk_i);
    pulse_fb();
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 cmp", cmp_pulse_o, 0);
    chk("R1 up", up_o, 0);
    chk("R1 dn", dn_o, 0);
    chk("R1 err", ratio_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 up after", up_o, 0);
    chk("R1 err after", ratio_err_o, 0);
  endtask

  task automatic t_period(input int r);
    int n;
    ratio_i = 15'(r);
    wait_pulse(n);
    wait_pulse(n);
    chk($sformatf("R2 period %0d", r), n, r);
    wait_pulse(n);
    chk($sformatf("R2 period again %0d", r), n, r);
    chk("R3 err low on legal", ratio_err_o, 0);
  endtask

  task automatic t_clamp(input int r);
    int n;
    ratio_i = 15'(r);
    wait_pulse(n);
    chk($sformatf("R3 err set for %0d", r), ratio_err_o, 1);
    wait_pulse(n);
    chk($sformatf("R3 clamped period for %0d", r), n, 3);
  endtask

  task automatic t_midchange();
    int n;
    ratio_i = 15'd10;
    wait_pulse(n);
    repeat (2) @(negedge clk_i);
    ratio_i = 15'd20;
    wait_pulse(n);
    chk("R4 old ratio finishes", n + 2, 10);
    wait_pulse(n);
    chk("R4 new ratio next", n, 20);
  endtask

  task automatic t_ref_lead();
    int n;
    ratio_i = 15'd20;
    invert_i = 1'b0;
    to_idle();
    wait_pulse(n);
    @(negedge clk_i);
    chk("R5 up on ref lead", up_o, 1);
    chk("R5 dn on ref lead", dn_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R5 up held", up_o, 1);
    pulse_fb();
    chk("R6 up cleared", up_o, 0);
    chk("R6 dn cleared", dn_o, 0);
  endtask

  task automatic t_fb_lead();
    int n;
    to_idle();
    repeat (3) @(negedge clk_i);
    pulse_fb();
    chk("R6 dn on fb lead", dn_o, 1);
    chk("R6 up on fb lead", up_o, 0);
    wait_pulse(n);
    @(negedge clk_i);
    chk("R6 both clear dn", dn_o, 0);
    chk("R6 both clear up", up_o, 0);
  endtask

  task automatic t_same_cycle();
    int n;
    to_idle();
    wait_pulse(n);
    fb_pulse_i = 1'b1;
    @(negedge clk_i);
    fb_pulse_i = 1'b0;
    chk("R7 up idle", up_o, 0);
    chk("R7 dn idle", dn_o, 0);
    @(negedge clk_i);
    chk("R7 still idle", up_o | dn_o, 0);
  endtask

  task automatic t_invert();
    int n;
    invert_i = 1'b1;
    to_idle();
    wait_pulse(n);
    @(negedge clk_i);
    chk("R8 dn on ref lead inverted", dn_o, 1);
    chk("R8 up on ref lead inverted", up_o, 0);
    invert_i = 1'b0;
    #1;
    chk("R9 swap back up", up_o, 1);
    chk("R9 swap back dn", dn_o, 0);
    @(negedge clk_i);
    invert_i = 1'b1;
    #1;
    chk("R9 state kept", dn_o, 1);
    @(negedge clk_i);
    pulse_fb();
    chk("R8 cleared", up_o | dn_o, 0);
    repeat (2) @(negedge clk_i);
    pulse_fb();
    chk("R8 up on fb lead inverted", up_o, 1);
    chk("R10 not both", up_o & dn_o, 0);
    invert_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_period(5);
    t_period(3);
    t_period(64);
    t_clamp(1);
    t_clamp(0);
    t_clamp(2);
    t_period(16);
    t_midchange();
    t_ref_lead();
    t_fb_lead();
    t_same_cycle();
    t_invert();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule